// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of sixteen 48-bit event counters that sits behind a simple register read/write port. Each counter has an event code of its own. In every cycle the counter counts the bit of a 256-bit event pulse vector that its code selects. A counter advances only when two bits are set: its own enable bit and one bank-wide run bit. Software can load any counter at any time. Loads go through 64-bit register slots whose top 16 bits are always zero.

When an enabled counter rolls over from all-ones to zero, it latches a pending bit. Each pending bit can be masked. A mask bit set to 1 blocks that counter's pending bit. The single interrupt output is high while any pending bit is unmasked. Software clears pending bits by writing ones to a clear register.

The register port takes 32-bit and 64-bit accesses at byte offsets. Read data is registered and appears in the cycle after the read request.

Top module: `evcnt_bank`

## Requirements
- R1: Counter i occupies a 64-bit slot at byte offset 0x1F00 + 8*i. A 64-bit access (bus_dword=1) reads or writes the whole counter. A 32-bit access at slot+0 covers bits [31:0]. A 32-bit access at slot+4 covers bits [47:32], which sit in the low bits of the data word.
- R2: Bits [63:48] of a counter slot always read as zero, and writing them has no effect on the counter.
- R3: Event codes are 8 bits, four per 32-bit select register at offsets 0x1E80 + 4*k. Counter i uses register i/4, bits [8*(i%4)+7 : 8*(i%4)]. The registers read back what was written.
- R4: Bit 0 of the run register at 0x1E00 gates the whole bank. While it is 0, no counter changes, except by a software write.
- R5: Bit i of the enable register at 0x1E04 enables counter i. A counter counts only when both its enable bit and the run bit are 1.
- R6: An enabled counter adds exactly 1 in each cycle in which events[code] is high. Several counters may count in the same cycle.
- R7: A counter whose code is 0xFF never increments, even when events[255] is high.
- R8: When an enabled counter wraps from all-ones to zero, bit i of the status register at 0x0808 is set and stays set. Writes to the status register have no effect.
- R9: Writing 1 to bit i of the clear register at 0x080C clears pending bit i. A wrap in the same cycle wins over the clear. The clear register reads as zero.
- R10: The mask register at 0x0804 resets to all-ones, and a 1 in it masks. irq is the OR of the pending bits whose mask bit is 0. irq follows the registered pending and mask state with no extra delay.
- R11: The register at 0x1CF0 reads as the VERSION_ID parameter and ignores writes.
- R12: A software write to a counter takes priority over an increment in the same cycle. This holds for either half of the counter. The counter takes the written value, and no wrap is flagged.
- R13: After reset, every register reads zero except the mask (all-ones) and the version register. Unmapped offsets read zero. Read data appears on bus_rdata in the cycle after bus_rd and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_dword | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 13 | Byte offset of the access |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| events | input | 256 | One-cycle event pulses, indexed by event code |
| irq | output | 1 | Interrupt: any unmasked pending bit |

## Verification
The counting function is tried with several input patterns:
- One code pulsed per counter a different number of times. This separates a counter that follows its own code from one that follows a neighbour's lane.
- All selected codes high together. This shows that counters advance independently in the same cycle.
- Pulses on an unselected code, and runs with the run bit or an enable bit cleared. These tell gating from counting.
- The full event vector held high with one code set to 0xFF. This isolates the no-event code.

Near-wrap preloads exercise the flag path:
- Masked and unmasked wraps.
- A clear that lands in the same cycle as a wrap.
- A write that lands in the same cycle as an increment.

Between them, these separate sticky, priority and masking behaviour.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
    localparam int ADDR_W = 13;
    localparam int IDX_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_MASK = 13'h0804;
    localparam logic [ADDR_W-1:0] OFS_STAT = 13'h0808;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 13'h080C;
    localparam logic [ADDR_W-1:0] OFS_VER  = 13'h1CF0;
    localparam logic [ADDR_W-1:0] OFS_RUN  = 13'h1E00;
    localparam logic [ADDR_W-1:0] OFS_CEN  = 13'h1E04;
    localparam logic [ADDR_W-1:0] OFS_SEL0 = 13'h1E80;
    localparam logic [ADDR_W-1:0] OFS_CNT0 = 13'h1F00;

    // one-hot-ish decode result of a register port address
    typedef struct packed {
        logic             mask;
        logic             stat;
        logic             clr;
        logic             ver;
        logic             run;
        logic             cen;
        logic             sel;
        logic             cnt;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } hit_t;
endpackage

// File: rtl/evcnt_decode.sv
module evcnt_decode
    import evcnt_pkg::*;
#(
    parameter int NUM_CNT = 16,
    parameter int NUM_SEL = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output hit_t              hit
);
    logic [ADDR_W-1:0] cnt_ofs;
    logic [ADDR_W-1:0] sel_ofs;

    always_comb begin
        cnt_ofs  = addr - OFS_CNT0;
        sel_ofs  = addr - OFS_SEL0;
        hit      = '0;
        hit.mask = (addr == OFS_MASK);
        hit.stat = (addr == OFS_STAT);
        hit.clr  = (addr == OFS_CLR);
        hit.ver  = (addr == OFS_VER);
        hit.run  = (addr == OFS_RUN);
        hit.cen  = (addr == OFS_CEN);
        if (addr >= OFS_CNT0 && cnt_ofs < ADDR_W'(8 * NUM_CNT)) begin
            hit.cnt = 1'b1;
            hit.hi  = addr[2];
            hit.idx = cnt_ofs[IDX_W+2:3];
        end else if (addr >= OFS_SEL0 && sel_ofs < ADDR_W'(4 * NUM_SEL)) begin
            hit.sel = 1'b1;
            hit.idx = sel_ofs[IDX_W+1:2];
        end
    end
endmodule

// File: rtl/evcnt_slice.sv
module evcnt_slice #(
    parameter int CNT_W  = 48,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     count_en,
    input  logic [CODE_W-1:0]        code,
    input  logic [(1<<CODE_W)-1:0]   events,
    input  logic                     wr_lo,
    input  logic                     wr_hi,
    input  logic [31:0]              lo_data,
    input  logic [CNT_W-33:0]        hi_data,
    output logic [CNT_W-1:0]         cnt,
    output logic                     wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } slice_t;

    slice_t slice_d, slice_q;
    logic   bump;

    always_comb begin
        slice_d = slice_q;
        wrap    = 1'b0;
        bump    = count_en && (code != '1) && events[code];
        if (wr_lo || wr_hi) begin
            if (wr_lo) slice_d.cnt[31:0]      = lo_data;
            if (wr_hi) slice_d.cnt[CNT_W-1:32] = hi_data;
        end else if (bump) begin
            slice_d.cnt = slice_q.cnt + 1'b1;
            wrap        = &slice_q.cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slice_q <= '0;
        else        slice_q <= slice_d;
    end

    assign cnt = slice_q.cnt;

    p_hold_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !wr_lo && !wr_hi) |=> $stable(slice_q.cnt));

    p_no_event_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '1 && !wr_lo && !wr_hi) |=> $stable(slice_q.cnt));

    p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=>
        (slice_q.cnt == $past(slice_q.cnt) || slice_q.cnt == $past(slice_q.cnt) + 1'b1));

    p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (slice_q.cnt[31:0] == $past(lo_data)));
endmodule

// File: rtl/evcnt_irq.sv
module evcnt_irq #(
    parameter int NUM_CNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr,
    input  logic               clr_wr,
    input  logic [NUM_CNT-1:0] wbits,
    input  logic [NUM_CNT-1:0] wrap,
    output logic [NUM_CNT-1:0] pend,
    output logic [NUM_CNT-1:0] mask,
    output logic               irq
);
    typedef struct packed {
        logic [NUM_CNT-1:0] pend;
        logic [NUM_CNT-1:0] mask;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (mask_wr) irq_d.mask = wbits;
        if (clr_wr)  irq_d.pend = irq_q.pend & ~wbits;
        irq_d.pend = irq_d.pend | wrap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q.pend <= '0;
            irq_q.mask <= '1;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign pend = irq_q.pend;
    assign mask = irq_q.mask;
    assign irq  = |(irq_q.pend & ~irq_q.mask);

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((irq_q.pend & $past(irq_q.pend)) == $past(irq_q.pend)));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap != '0) |=> ((irq_q.pend & $past(wrap)) == $past(wrap)));
endmodule

// File: rtl/evcnt_bank.sv
module evcnt_bank
    import evcnt_pkg::*;
#(
    parameter int          NUM_CNT    = 16,
    parameter int          CNT_W      = 48,
    parameter int          CODE_W     = 8,
    parameter logic [31:0] VERSION_ID = 32'h0002_0001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic                    bus_rd,
    input  logic                    bus_dword,
    input  logic [12:0]             bus_addr,
    input  logic [63:0]             bus_wdata,
    output logic [63:0]             bus_rdata,
    input  logic [(1<<CODE_W)-1:0]  events,
    output logic                    irq
);
    localparam int LANES   = 32 / CODE_W;
    localparam int NUM_SEL = (NUM_CNT + LANES - 1) / LANES;
    localparam int CIDX_W  = $clog2(NUM_CNT);
    localparam int HI_W    = CNT_W - 32;

    typedef struct packed {
        logic                            run;
        logic [NUM_CNT-1:0]              cen;
        logic [NUM_CNT-1:0][CODE_W-1:0]  sel;
        logic [63:0]                     rdata;
    } bank_t;

    bank_t              bank_d, bank_q;
    hit_t               hit;
    logic [CNT_W-1:0]   cnt_all [NUM_CNT];
    logic [NUM_CNT-1:0] wrap_v;
    logic [NUM_CNT-1:0] pend_v;
    logic [NUM_CNT-1:0] mask_v;
    logic [NUM_CNT-1:0] wr_lo_v;
    logic [NUM_CNT-1:0] wr_hi_v;
    logic [HI_W-1:0]    hi_data;
    logic [63:0]        rd_word;
    logic [63:0]        cnt_word;
    logic [31:0]        word32;

    evcnt_decode #(.NUM_CNT(NUM_CNT), .NUM_SEL(NUM_SEL)) u_decode (
        .addr (bus_addr),
        .hit  (hit)
    );

    assign hi_data = bus_dword ? bus_wdata[CNT_W-1:32] : bus_wdata[HI_W-1:0];

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_slice
        assign wr_lo_v[gi] = bus_wr && hit.cnt && (hit.idx == IDX_W'(gi)) && (bus_dword || !hit.hi);
        assign wr_hi_v[gi] = bus_wr && hit.cnt && (hit.idx == IDX_W'(gi)) && (bus_dword || hit.hi);

        evcnt_slice #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (bank_q.run && bank_q.cen[gi]),
            .code     (bank_q.sel[gi]),
            .events   (events),
            .wr_lo    (wr_lo_v[gi]),
            .wr_hi    (wr_hi_v[gi]),
            .lo_data  (bus_wdata[31:0]),
            .hi_data  (hi_data),
            .cnt      (cnt_all[gi]),
            .wrap     (wrap_v[gi])
        );
    end

    evcnt_irq #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_wr (bus_wr && hit.mask),
        .clr_wr  (bus_wr && hit.clr),
        .wbits   (bus_wdata[NUM_CNT-1:0]),
        .wrap    (wrap_v),
        .pend    (pend_v),
        .mask    (mask_v),
        .irq     (irq)
    );

    always_comb begin
        bank_d = bank_q;

        // control writes
        if (bus_wr && hit.run) bank_d.run = bus_wdata[0];
        if (bus_wr && hit.cen) bank_d.cen = bus_wdata[NUM_CNT-1:0];
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_wr && hit.sel && (int'(hit.idx) == i / LANES))
                bank_d.sel[i] = bus_wdata[(i % LANES) * CODE_W +: CODE_W];
        end

        // read path
        word32   = '0;
        cnt_word = '0;
        rd_word  = '0;
        if (hit.mask) begin
            word32[NUM_CNT-1:0] = mask_v;
        end else if (hit.stat) begin
            word32[NUM_CNT-1:0] = pend_v;
        end else if (hit.ver) begin
            word32 = VERSION_ID;
        end else if (hit.run) begin
            word32[0] = bank_q.run;
        end else if (hit.cen) begin
            word32[NUM_CNT-1:0] = bank_q.cen;
        end else if (hit.sel) begin
            for (int j = 0; j < LANES; j++) begin
                if (int'(hit.idx) * LANES + j < NUM_CNT)
                    word32[j*CODE_W +: CODE_W] = bank_q.sel[int'(hit.idx) * LANES + j];
            end
        end
        if (hit.cnt) begin
            cnt_word[CNT_W-1:0] = cnt_all[hit.idx[CIDX_W-1:0]];
            if (bus_dword)    rd_word = cnt_word;
            else if (hit.hi)  rd_word = {32'h0, cnt_word[63:32]};
            else              rd_word = {32'h0, cnt_word[31:0]};
        end else begin
            rd_word = {32'h0, word32};
        end
        if (bus_rd) bank_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign bus_rdata = bank_q.rdata;

    p_slot_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit.cnt && bus_dword) |=> (bus_rdata[63:CNT_W] == '0));

    p_clear_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit.clr) |=> (bus_rdata == 64'h0));

    p_version_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit.ver) |=> (bus_rdata == {32'h0, VERSION_ID}));

    p_full_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit.mask && bus_wdata[NUM_CNT-1:0] == '1) |=> !irq);
endmodule

// File: tb/evcnt_bank_test.sv
`timescale 1ns/1ps
module evcnt_bank_test;
    localparam logic [31:0] VER = 32'h0002_0001;
    localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_dword = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [255:0] events = '0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [47:0] expc [16];

    evcnt_bank #(.VERSION_ID(VER)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_dword(bus_dword), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .events(events), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] code_of(input int i);
        return 8'((i * 13 + 7) & 8'hFF);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [63:0] d, input logic dw);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_dword = dw;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, input logic dw, output logic [63:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a; bus_dword = dw;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] c, input int n);
        @(negedge clk);
        events = '0;
        events[c] = 1'b1;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    task automatic check_all(input string tag);
        logic [63:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(13'h1F00 + 13'(8 * i), 1'b1, v);
            chk(tag, v, {16'h0, expc[i]});
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(13'h0804, 1'b0, v); chk("R10 mask reset", v, 64'hFFFF);
        rd(13'h0808, 1'b0, v); chk("R13 status reset", v, 64'h0);
        rd(13'h1F00, 1'b1, v); chk("R13 counter reset", v, 64'h0);
        rd(13'h1E00, 1'b0, v); chk("R13 run reset", v, 64'h0);
        rd(13'h0100, 1'b0, v); chk("R13 unmapped", v, 64'h0);
        rd(13'h1CF0, 1'b0, v); chk("R11 version", v, {32'h0, VER});
        chk("R10 irq reset", 64'(irq), 64'h0);

        // slot layout and upper-bit behaviour
        wr(13'h1F18, 64'hABCD_1234_5678_9ABC, 1'b1);
        rd(13'h1F18, 1'b1, v); chk("R2 upper ignored", v, 64'h0000_1234_5678_9ABC);
        rd(13'h1F18, 1'b0, v); chk("R1 low word", v, 64'h5678_9ABC);
        rd(13'h1F1C, 1'b0, v); chk("R1 high word", v, 64'h1234);
        wr(13'h1F1C, 64'hFFFF_5555, 1'b0);
        rd(13'h1F18, 1'b1, v); chk("R1 high half write", v, 64'h5555_5678_9ABC);
        wr(13'h1F18, 64'h1111_2222, 1'b0);
        rd(13'h1F18, 1'b1, v); chk("R1 low half write", v, 64'h5555_1111_2222);
        wr(13'h1F18, 64'h0, 1'b1);

        // select register packing
        for (int k = 0; k < 4; k++)
            wr(13'h1E80 + 13'(4 * k), {32'h0, code_of(4*k+3), code_of(4*k+2),
                                       code_of(4*k+1), code_of(4*k)}, 1'b0);
        for (int k = 0; k < 4; k++) begin
            rd(13'h1E80 + 13'(4 * k), 1'b0, v);
            chk("R3 select readback", v, {32'h0, code_of(4*k+3), code_of(4*k+2),
                                          code_of(4*k+1), code_of(4*k)});
        end
        for (int i = 0; i < 16; i++) expc[i] = '0;

        // run bit off: nothing counts
        wr(13'h1E04, 64'hFFFF, 1'b0);
        for (int i = 0; i < 16; i++) pulse(code_of(i), i + 1);
        check_all("R4 run bit off");

        // run on: counter i gets i+1 pulses of its own code
        wr(13'h1E00, 64'h1, 1'b0);
        for (int i = 0; i < 16; i++) begin
            pulse(code_of(i), i + 1);
            expc[i] = expc[i] + 48'(i + 1);
        end
        pulse(8'h00, 5);
        check_all("R6 per-code sweep");

        // only even counters enabled
        wr(13'h1E04, 64'h5555, 1'b0);
        for (int i = 0; i < 16; i++) begin
            pulse(code_of(i), 3);
            if (i % 2 == 0) expc[i] = expc[i] + 48'd3;
        end
        check_all("R5 per-counter enable");

        // all selected codes at once
        wr(13'h1E04, 64'hFFFF, 1'b0);
        @(negedge clk);
        for (int i = 0; i < 16; i++) events[code_of(i)] = 1'b1;
        repeat (4) @(negedge clk);
        events = '0;
        for (int i = 0; i < 16; i++) expc[i] = expc[i] + 48'd4;
        check_all("R6 simultaneous events");

        // code 0xFF on counter 0, full event vector high
        wr(13'h1E80, {32'h0, code_of(3), code_of(2), code_of(1), 8'hFF}, 1'b0);
        @(negedge clk);
        events = '1;
        repeat (3) @(negedge clk);
        events = '0;
        for (int i = 1; i < 16; i++) expc[i] = expc[i] + 48'd3;
        check_all("R7 no-event code");

        // wrap with interrupt masked, then unmasked
        wr(13'h1F28, {16'h0, ONES - 48'd1}, 1'b1);
        pulse(code_of(5), 1);
        rd(13'h0808, 1'b0, v); chk("R8 no flag before wrap", v, 64'h0);
        pulse(code_of(5), 1);
        rd(13'h1F28, 1'b1, v); chk("R8 counter wrapped", v, 64'h0);
        rd(13'h0808, 1'b0, v); chk("R8 flag after wrap", v, 64'h20);
        chk("R10 masked irq", 64'(irq), 64'h0);
        wr(13'h0808, 64'h0, 1'b0);
        rd(13'h0808, 1'b0, v); chk("R8 status write ignored", v, 64'h20);
        wr(13'h0804, 64'hFFDF, 1'b0);
        chk("R10 unmasked irq", 64'(irq), 64'h1);

        // write-one clear
        wr(13'h080C, 64'h20, 1'b0);
        rd(13'h0808, 1'b0, v); chk("R9 cleared", v, 64'h0);
        chk("R9 irq dropped", 64'(irq), 64'h0);
        rd(13'h080C, 1'b0, v); chk("R9 clear reads zero", v, 64'h0);

        // wrap and clear in the same cycle: wrap wins
        wr(13'h1F28, {16'h0, ONES}, 1'b1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 13'h080C; bus_wdata = 64'h20; bus_dword = 1'b0;
        events[code_of(5)] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; events = '0;
        rd(13'h0808, 1'b0, v); chk("R9 set beats clear", v, 64'h20);
        chk("R10 irq on set", 64'(irq), 64'h1);
        wr(13'h080C, 64'h20, 1'b0);

        // write and increment in the same cycle: write wins
        wr(13'h1F38, {16'h0, ONES}, 1'b1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 13'h1F38; bus_wdata = 64'h100; bus_dword = 1'b1;
        events[code_of(7)] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; events = '0;
        rd(13'h1F38, 1'b1, v); chk("R12 write beats increment", v, 64'h100);
        rd(13'h0808, 1'b0, v); chk("R12 no wrap flag", v, 64'h0);

        // version ignores writes
        wr(13'h1CF0, 64'h0, 1'b0);
        rd(13'h1CF0, 1'b0, v); chk("R11 version read-only", v, {32'h0, VER});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule